// File: doc/BRIEF.md
# Unlock-Sequence Command Detector

This block sits beside a memory bus whose accesses have already been reduced to one record per clock: a chip-select strobe, a read strobe, a write strobe and the address. It looks for a fixed, ordered run of six read accesses. The first five reads must land on five fixed key addresses. The sixth read selects one of four maintenance commands: commit the array to nonvolatile storage, restore the array from it, turn the power-loss automatic commit off, or turn it back on. When a command is selected, the block raises a single-cycle pulse on the matching output.

Only a 13-bit window of the address, bits 14 down to 2, is compared. All other address bits are ignored. A write, or a read that does not continue the run, breaks the run. Clocks that carry no access leave the run as it is, so the sequence may be spread out in time. The current match depth is exposed so that a debugger or a neighbouring block can see how far the run has progressed.

Top module: `seqcmd_detector`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) sets `match_depth` to 0 and holds all four command outputs low.
- R2: An access is a clock with `bus_sel` high and at least one of `bus_rd`, `bus_wr` high. A read access whose key (address bits 14..2) equals the key of 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, in that order, advances `match_depth` by one at that clock edge, from 0 up to 5.
- R3: A read access at depth 5 with the key of 0x8FC0 pulses `cmd_store`. The key of 0x4C63 pulses `cmd_recall`, 0x8B45 pulses `cmd_as_off` and 0x4B46 pulses `cmd_as_on`. The pulse is high for exactly the one cycle that follows the clock edge sampling that read.
- R4: Address bits outside 14..2, including bits 1, 0 and every bit above 14, have no effect on matching or decoding.
- R5: A write access (`bus_sel` and `bus_wr` high) at any depth returns `match_depth` to 0 and issues no command.
- R6: A clock with `bus_sel`, `bus_rd` and `bus_wr` all high counts as a write and not as a read step, even if its address matches the next key.
- R7: A read access at depths 0 to 4 that does not match the next key aborts the run. It leaves `match_depth` at 1 if its key equals the key of 0x4E38, and at 0 otherwise.
- R8: The read at depth 5 always returns `match_depth` to 0. If its key matches none of the four command keys, no command output pulses, even if it matches the first key.
- R9: Clocks without an access (`bus_sel` low, or neither strobe high) leave `match_depth` unchanged and pulse no command.
- R10: At most one command output is high in any cycle, and a command output is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one access record per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Chip select for this cycle, active high |
| bus_rd | input | 1 | Read strobe for this cycle, active high |
| bus_wr | input | 1 | Write strobe for this cycle, active high |
| bus_addr | input | ADDR_W (17) | Access address |
| cmd_store | output | 1 | One-cycle pulse: commit to nonvolatile storage |
| cmd_recall | output | 1 | One-cycle pulse: restore from nonvolatile storage |
| cmd_as_off | output | 1 | One-cycle pulse: disable automatic commit |
| cmd_as_on | output | 1 | One-cycle pulse: enable automatic commit |
| match_depth | output | 3 | Number of key reads matched so far (0..5) |

## Verification
The bench runs every command with keys whose don't-care bits are flipped. A detector that compared the full address would never fire on these. A read that carries both strobes is placed at depth 4 with the correct next address; a design that let the read strobe win would advance to depth 5. Mid-run reads are checked both with an unrelated address and with the first key, so a detector that threw away the restart read would sit at 0 where 1 is expected. At depth 5, an unknown address and the first key must both give depth 0 and no pulse. Idle clocks, including a deselected write, are mixed into runs, so a design that treated them as aborts would lose its depth.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

  localparam int PREFIX_LEN = 5;
  localparam int NUM_CMDS   = 4;
  localparam int KEY_LO     = 2;
  localparam int KEY_HI     = 14;
  localparam int KEY_W      = KEY_HI - KEY_LO + 1;
  localparam int DEPTH_W    = $clog2(PREFIX_LEN + 1);

  typedef logic [KEY_W-1:0]   key_t;
  typedef logic [DEPTH_W-1:0] depth_t;

  // Command slot order; also the bit order of the fire vector.
  localparam int CMD_STORE  = 0;
  localparam int CMD_RECALL = 1;
  localparam int CMD_AS_OFF = 2;
  localparam int CMD_AS_ON  = 3;

  // Unlock key addresses, in the order the run must present them.
  function automatic logic [15:0] prefix_word(input int idx);
    logic [15:0] w;
    case (idx)
      0:       w = 16'h4E38;
      1:       w = 16'hB1C7;
      2:       w = 16'h83E0;
      3:       w = 16'h7C1F;
      default: w = 16'h703F;
    endcase
    return w;
  endfunction

  // Final-step addresses, indexed by command slot.
  function automatic logic [15:0] cmd_word(input int idx);
    logic [15:0] w;
    case (idx)
      CMD_STORE:  w = 16'h8FC0;
      CMD_RECALL: w = 16'h4C63;
      CMD_AS_OFF: w = 16'h8B45;
      default:    w = 16'h4B46;
    endcase
    return w;
  endfunction

  // Compared window of a 16-bit constant.
  function automatic key_t key_of_word(input logic [15:0] w);
    return w[KEY_HI:KEY_LO];
  endfunction

  function automatic key_t prefix_key(input int idx);
    return key_of_word(prefix_word(idx));
  endfunction

  function automatic key_t cmd_key(input int idx);
    return key_of_word(cmd_word(idx));
  endfunction

  // Depth after a read that matched; saturation is handled by the caller.
  function automatic depth_t depth_advance(input depth_t d);
    return d + depth_t'(1);
  endfunction

endpackage

// File: rtl/seqcmd_access_class.sv
module seqcmd_access_class (
  input  logic bus_sel,
  input  logic bus_rd,
  input  logic bus_wr,
  output logic acc_any,
  output logic acc_read,
  output logic acc_write
);

  // A write strobe dominates: a cycle with both strobes is a write.
  always_comb begin
    acc_write = bus_sel & bus_wr;
    acc_read  = bus_sel & bus_rd & ~bus_wr;
    acc_any   = acc_write | acc_read;
  end

endmodule

// File: rtl/seqcmd_key_match.sv
module seqcmd_key_match
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [PREFIX_LEN-1:0] prefix_hit,
  output logic [NUM_CMDS-1:0]   cmd_hit
);

  key_t addr_key;
  assign addr_key = addr[KEY_HI:KEY_LO];

  for (genvar gi = 0; gi < PREFIX_LEN; gi++) begin : g_prefix
    localparam key_t KEY = prefix_key(gi);
    assign prefix_hit[gi] = (addr_key == KEY);
  end

  for (genvar gc = 0; gc < NUM_CMDS; gc++) begin : g_cmd
    localparam key_t KEY = cmd_key(gc);
    assign cmd_hit[gc] = (addr_key == KEY);
  end

endmodule

// File: rtl/seqcmd_seq_track.sv
module seqcmd_seq_track
  import seqcmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_read,
  input  logic                  acc_write,
  input  logic [PREFIX_LEN-1:0] prefix_hit,
  input  logic [NUM_CMDS-1:0]   cmd_hit,
  output depth_t                depth,
  output logic [NUM_CMDS-1:0]   fire
);

  localparam depth_t LAST = depth_t'(PREFIX_LEN);

  depth_t depth_nxt;
  logic   step_hit;

  // Hit for the key expected at the current depth.
  always_comb begin
    step_hit = 1'b0;
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (depth == depth_t'(i)) step_hit = prefix_hit[i];
    end
  end

  always_comb begin
    depth_nxt = depth;
    fire      = '0;
    if (acc_write) begin
      depth_nxt = '0;
    end else if (acc_read) begin
      if (depth == LAST) begin
        depth_nxt = '0;
        fire      = cmd_hit;
      end else if (step_hit) begin
        depth_nxt = depth_advance(depth);
      end else if (prefix_hit[0]) begin
        depth_nxt = depth_t'(1);
      end else begin
        depth_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) depth <= '0;
    else        depth <= depth_nxt;
  end

endmodule

// File: rtl/seqcmd_pulse_reg.sv
module seqcmd_pulse_reg
  import seqcmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CMDS-1:0] fire,
  output logic [NUM_CMDS-1:0] pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= '0;
    else        pulse <= fire;
  end

endmodule

// File: rtl/seqcmd_detector.sv
module seqcmd_detector
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic               cmd_store,
  output logic               cmd_recall,
  output logic               cmd_as_off,
  output logic               cmd_as_on,
  output logic [DEPTH_W-1:0] match_depth
);

  logic                  acc_any;
  logic                  acc_read;
  logic                  acc_write;
  logic [PREFIX_LEN-1:0] prefix_hit;
  logic [NUM_CMDS-1:0]   cmd_hit;
  logic [NUM_CMDS-1:0]   fire;
  logic [NUM_CMDS-1:0]   pulse;
  depth_t                depth;

  seqcmd_access_class u_class (
    .bus_sel   (bus_sel),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .acc_any   (acc_any),
    .acc_read  (acc_read),
    .acc_write (acc_write)
  );

  seqcmd_key_match #(.ADDR_W(ADDR_W)) u_match (
    .addr       (bus_addr),
    .prefix_hit (prefix_hit),
    .cmd_hit    (cmd_hit)
  );

  seqcmd_seq_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_read   (acc_read),
    .acc_write  (acc_write),
    .prefix_hit (prefix_hit),
    .cmd_hit    (cmd_hit),
    .depth      (depth),
    .fire       (fire)
  );

  seqcmd_pulse_reg u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .pulse (pulse)
  );

  assign cmd_store   = pulse[CMD_STORE];
  assign cmd_recall  = pulse[CMD_RECALL];
  assign cmd_as_off  = pulse[CMD_AS_OFF];
  assign cmd_as_on   = pulse[CMD_AS_ON];
  assign match_depth = depth;

endmodule

// File: rtl/seqcmd_detector_chk.sv
module seqcmd_detector_chk
  import seqcmd_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                acc_any,
  input logic                acc_read,
  input logic                acc_write,
  input logic [NUM_CMDS-1:0] pulse,
  input depth_t              depth
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (depth == '0 && pulse == '0)); // R1

  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= depth_t'(PREFIX_LEN)); // R2

  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    acc_read |=> (depth == $past(depth) + depth_t'(1) || depth <= depth_t'(1))); // R7

  AST_CMD_AFTER_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |-> ($past(depth) == depth_t'(PREFIX_LEN) && $past(acc_read))); // R3

  AST_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_write |=> (depth == '0 && pulse == '0)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_any |=> ($stable(depth) && pulse == '0)); // R9

  AST_CMD_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |-> depth == '0); // R8

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse)); // R10

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |=> (pulse == '0)); // R10

endmodule

bind seqcmd_detector seqcmd_detector_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_any   (acc_any),
  .acc_read  (acc_read),
  .acc_write (acc_write),
  .pulse     (pulse),
  .depth     (depth)
);

// File: tb/seqcmd_detector_tb.sv
module seqcmd_detector_tb;

  typedef struct {
    int    depth;
    int    cmds;   // {store, recall, as_off, as_on}
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [16:0] bus_addr = '0;
  logic        cmd_store, cmd_recall, cmd_as_off, cmd_as_on;
  logic [2:0]  match_depth;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  exp_t sb[$];

  // Reference model state
  int m_depth = 0;

  int prefix_addr[5] = '{32'h4E38, 32'hB1C7, 32'h83E0, 32'h7C1F, 32'h703F};
  int final_addr[4]  = '{32'h8FC0, 32'h4C63, 32'h8B45, 32'h4B46};

  always #2 clk = ~clk;

  seqcmd_detector u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .cmd_store(cmd_store),
    .cmd_recall(cmd_recall), .cmd_as_off(cmd_as_off), .cmd_as_on(cmd_as_on),
    .match_depth(match_depth)
  );

  function automatic int wkey(input int a);
    return (a / 4) % 8192;
  endfunction

  // Model: returns expected command bits for one bus record.
  function automatic int model_step(input bit sel, input bit rd, input bit wr, input int a);
    int c = 0;
    if (sel && wr) m_depth = 0;
    else if (sel && rd) begin
      if (m_depth == 5) begin
        for (int k = 0; k < 4; k++)
          if (wkey(a) == wkey(final_addr[k])) c = 8 >> k;
        m_depth = 0;
      end else if (wkey(a) == wkey(prefix_addr[m_depth])) m_depth++;
      else if (wkey(a) == wkey(prefix_addr[0])) m_depth = 1;
      else m_depth = 0;
    end
    return c;
  endfunction

  task automatic drive(input bit sel, input bit rd, input bit wr, input int a, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = 1'b1; bus_sel = sel; bus_rd = rd; bus_wr = wr; bus_addr = 17'(a);
    e.cmds = model_step(sel, rd, wr, a);
    e.depth = m_depth; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic do_reset(input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = 1'b0; bus_sel = 1'b1; bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = 17'h04E38;
    m_depth = 0;
    e.depth = 0; e.cmds = 0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic rd(input int a, input string tag);
    drive(1, 1, 0, a, tag);
  endtask

  task automatic prefix(input int upto, input int flip, input string tag);
    for (int i = 0; i < upto; i++) rd(prefix_addr[i] ^ flip, tag);
  endtask

  // Monitor: compare one expected item per cycle, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      int got;
      e = sb.pop_front();
      got = {28'd0, cmd_store, cmd_recall, cmd_as_off, cmd_as_on};
      n_checks++;
      if (int'(match_depth) != e.depth || got != e.cmds) begin
        n_fail++;
        $display("FAIL %s: depth=%0d cmds=%b expected depth=%0d cmds=%b",
                 e.tag, match_depth, got[3:0], e.depth, e.cmds[3:0]);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset");
    do_reset("R1 reset");
    // R2 + R3: each command
    prefix(5, 0, "R2 prefix"); rd(32'h8FC0, "R3 store");
    drive(0, 0, 0, 0, "R3 pulse one cycle");
    prefix(5, 0, "R2 prefix"); rd(32'h4C63, "R3 recall");
    prefix(5, 0, "R2 prefix"); rd(32'h8B45, "R3 as_off");
    prefix(5, 0, "R2 prefix"); rd(32'h4B46, "R3 as_on");
    // R4: flip bits 16,15,1,0
    prefix(5, 32'h18003, "R4 masked prefix"); rd(32'h8FC0 ^ 32'h18003, "R4 masked store");
    prefix(5, 32'h10002, "R4 masked prefix"); rd(32'h4B46 ^ 32'h08001, "R4 masked as_on");
    // R5: write abort at depth 3
    prefix(3, 0, "R5 setup"); drive(1, 0, 1, 32'h7C1F, "R5 write abort");
    rd(32'h703F, "R5 no resume");
    // R6: both strobes at depth 4 with the right next address
    prefix(4, 0, "R6 setup"); drive(1, 1, 1, 32'h703F, "R6 write wins");
    // R7: unrelated mismatch, then restart by first key
    prefix(2, 0, "R7 setup"); rd(32'h1234, "R7 mismatch abort");
    prefix(3, 0, "R7 setup"); rd(32'h4E38, "R7 restart depth1");
    for (int i = 1; i < 5; i++) rd(prefix_addr[i], "R7 continue after restart");
    rd(32'h4C63, "R7 recall after restart");
    // R8: unmatched sixth, first key as sixth
    prefix(5, 0, "R8 setup"); rd(32'h1234, "R8 unmatched sixth");
    prefix(5, 0, "R8 setup"); rd(32'h4E38, "R8 first key as sixth");
    rd(32'hB1C7, "R8 idle after sixth");
    // R9: idle cycles mid-run
    prefix(2, 0, "R9 setup");
    drive(0, 1, 0, 32'h1234, "R9 deselected read");
    drive(0, 0, 1, 32'h1234, "R9 deselected write");
    drive(1, 0, 0, 32'h1234, "R9 no strobe");
    for (int i = 2; i < 5; i++) rd(prefix_addr[i], "R9 continue");
    drive(0, 0, 0, 0, "R9 idle at depth5");
    rd(32'h8B45, "R9 as_off after idle");
    // R10: back to back commands
    prefix(5, 0, "R10 setup"); rd(32'h8FC0, "R10 first");
    prefix(5, 0, "R10 setup"); rd(32'h4B46, "R10 second");
    // R1: reset mid-run
    prefix(4, 0, "R1 setup"); do_reset("R1 mid-run reset");
    rd(32'h703F, "R1 no resume after reset");
    repeat (3) drive(0, 0, 0, 0, "drain");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule